// File: doc/BRIEF.md
# Contiguous Memory Size Calculator

This block works out how much memory is reachable as one unbroken address range starting at the lowest populated bank. It sees two memory controllers, each able to drive up to two chips. Each chip has a 32-bit layout word. The top byte of the word gives the base address and the next byte is an address mask. A controller that is switched off contributes no chips. The second chip of a controller counts only when that controller reports at least one extra chip.

On a `valid_in` pulse the four layout words are captured. Any missing chip is replaced by an all-ones word, so it sorts behind every real bank. The four words are put in ascending order by a fixed five-step compare-exchange network and stored in a first register stage. A second stage turns each sorted word into an address range. It then adds up the lengths of the banks that follow one another with no hole, stopping at the first gap. The result appears on `size_out` with a one-cycle `size_valid` strobe. Start-up code uses it to learn the usable linear memory size.

Top module: `memsize_calc`

## Requirements
- R1: `size_valid` goes high exactly two clock edges after the edge that samples `valid_in` high, for one cycle per input pulse. Back-to-back pulses give back-to-back strobes.
- R2: While `rst_n` is low at a clock edge, `size_valid` and `size_out` become 0.
- R3: Entries are ordered as controller 0 chip 0, controller 0 chip 1, controller 1 chip 0, controller 1 chip 1. A chip-0 word is used only if its controller's enable bit is 1. A chip-1 word is used only if the controller is enabled and its 4-bit extra-chip count is nonzero. That count is the field held in bits 19:16 of the controller's control word. Any unused entry is taken as 0xFFFFFFFF.
- R4: The entries are sorted unsigned ascending by compare-exchange on index pairs (0,2), (1,3), (0,1), (2,3), (1,2), in that order. Each exchange leaves the smaller value at the lower index.
- R5: For a word w, the bank start is w & 0xFF000000. The bank end is start | ~((w & 0x00FF0000) << 8). The length is end − start + 1. Bits 15:0 have no effect.
- R6: The size starts as the length of the smallest sorted bank. Each next sorted bank is added while its start equals the previous bank's end + 1. The first mismatch ends the sum.
- R7: If the smallest sorted entry is 0xFFFFFFFF, the size is 0.
- R8: All length arithmetic is modulo 2^32, so banks that cover the full 4 GiB give a size of 0.
- R9: `size_out` keeps its value in every cycle in which `size_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_in | input | 1 | Capture the layout inputs this cycle |
| ctl_en | input | 2 | Per-controller enable, bit k for controller k |
| ctl_xchip | input | 8 | Per-controller extra-chip count, bits 4k+3:4k for controller k |
| cfg_chip0 | input | 64 | Chip-0 layout words, bits 32k+31:32k for controller k |
| cfg_chip1 | input | 64 | Chip-1 layout words, bits 32k+31:32k for controller k |
| size_out | output | 32 | Contiguous size in bytes, modulo 2^32 |
| size_valid | output | 1 | One-cycle strobe marking a new `size_out` |

## Verification
A wrong swap in the sorting network leaves the first stage out of order. That shows up at the ports as a size that starts from the wrong bank, or that ends the chain too early, on the strobe two cycles after the request. An error in selecting the enabled chips or in decoding a bank range shows the same way, on that same strobe, as a size that is wrong by whole bank lengths. A broken valid pipeline shows as a strobe that is missing, late, or doubled. Random layouts built from aligned banks make chained and gapped cases both common. Directed cases cover the empty set, full coverage of the address space, and the ignored low bits.

// File: rtl/memsize_pkg.sv
// Shared constants, types and the bank-range decode used by the size calculator.
// Assumes a 32-bit layout word: base byte on top, mask byte just below it.
package memsize_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned FIELD_W = 8;
    localparam int unsigned NCTL    = 2;
    localparam int unsigned NCHIP   = 2;
    localparam int unsigned NBANK   = NCTL * NCHIP;
    localparam int unsigned NSWAP   = 5;
    localparam int unsigned XCNT_W  = 4;
    localparam int unsigned LOW_W   = WORD_W - FIELD_W;

    // Compare-exchange schedule of the four-input sorting network
    localparam int SWAP_LO [NSWAP] = '{0, 1, 0, 2, 1};
    localparam int SWAP_HI [NSWAP] = '{2, 3, 1, 3, 2};

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t first;
        word_t last;
    } span_t;

    localparam word_t ABSENT = {WORD_W{1'b1}};

    // Turn one layout word into its first and last byte address
    function automatic span_t word_to_span(input word_t w);
        span_t s;
        logic [FIELD_W-1:0] base_b;
        logic [FIELD_W-1:0] mask_b;
        base_b  = w[WORD_W-1 -: FIELD_W];
        mask_b  = w[WORD_W-FIELD_W-1 -: FIELD_W];
        s.first = {base_b, {LOW_W{1'b0}}};
        s.last  = {base_b | ~mask_b, {LOW_W{1'b1}}};
        return s;
    endfunction

endpackage

// File: rtl/memsize_select.sv
// Builds the four sort entries from the per-controller layout words.
// Assumes entry order ctl0/chip0, ctl0/chip1, ctl1/chip0, ctl1/chip1;
// entries that are not populated are forced to all-ones.
module memsize_select
    import memsize_pkg::*;
(
    input  logic [NCTL-1:0]          ctl_en,
    input  logic [NCTL*XCNT_W-1:0]   ctl_xchip,
    input  logic [NCTL*WORD_W-1:0]   cfg_chip0,
    input  logic [NCTL*WORD_W-1:0]   cfg_chip1,
    output word_t [NBANK-1:0]        entry
);

    for (genvar c = 0; c < int'(NCTL); c++) begin : g_ctl
        logic has_second;
        // Second chip counts only on an enabled controller with extra chips
        always_comb begin
            has_second = ctl_en[c] && (ctl_xchip[c*XCNT_W +: XCNT_W] != '0);
        end
        // Pick the real word or the absent marker for each chip
        always_comb begin
            entry[c*NCHIP]     = ctl_en[c] ? cfg_chip0[c*WORD_W +: WORD_W] : ABSENT;
            entry[c*NCHIP + 1] = has_second ? cfg_chip1[c*WORD_W +: WORD_W] : ABSENT;
        end
    end

endmodule

// File: rtl/memsize_sortnet.sv
// Five compare-exchange sorting network over four unsigned words.
// Assumes the fixed schedule in the package; smaller value moves to lower index.
module memsize_sortnet
    import memsize_pkg::*;
(
    input  word_t [NBANK-1:0] din,
    output word_t [NBANK-1:0] dout
);

    word_t [NBANK-1:0] lvl [NSWAP+1];

    // Network input level
    always_comb begin
        lvl[0] = din;
    end

    for (genvar k = 0; k < int'(NSWAP); k++) begin : g_step
        localparam int LO = SWAP_LO[k];
        localparam int HI = SWAP_HI[k];
        logic swap;
        // Decide whether this pair is out of order
        always_comb begin
            swap = lvl[k][HI] < lvl[k][LO];
        end
        for (genvar j = 0; j < int'(NBANK); j++) begin : g_lane
            // Route each lane through this exchange step
            always_comb begin
                if (j == LO)
                    lvl[k+1][j] = swap ? lvl[k][HI] : lvl[k][LO];
                else if (j == HI)
                    lvl[k+1][j] = swap ? lvl[k][LO] : lvl[k][HI];
                else
                    lvl[k+1][j] = lvl[k][j];
            end
        end
    end

    // Network output level
    always_comb begin
        dout = lvl[NSWAP];
    end

endmodule

// File: rtl/memsize_chain.sv
// Decodes the sorted entries into ranges and sums the unbroken run from the
// lowest one. Assumes entries already ascending; arithmetic wraps at 2^32.
module memsize_chain
    import memsize_pkg::*;
(
    input  word_t [NBANK-1:0] sorted,
    output word_t             total
);

    span_t [NBANK-1:0] span;
    word_t [NBANK-1:0] blen;
    logic  [NBANK-1:0] joins;

    for (genvar i = 0; i < int'(NBANK); i++) begin : g_dec
        // Range and length of one bank
        always_comb begin
            span[i] = word_to_span(sorted[i]);
            blen[i] = span[i].last - span[i].first + word_t'(1);
        end
        if (i == 0) begin : g_head
            // Lowest bank always opens the run
            always_comb joins[i] = 1'b1;
        end else begin : g_link
            // Bank touches the one below it
            always_comb joins[i] = (span[i].first == word_t'(span[i-1].last + word_t'(1)));
        end
    end

    // Accumulate up to the first gap, or report zero when nothing is present
    always_comb begin
        logic run;
        total = '0;
        run   = 1'b1;
        for (int i = 0; i < int'(NBANK); i++) begin
            run = run & joins[i];
            if (run)
                total = total + blen[i];
        end
        if (sorted[0] == ABSENT)
            total = '0;
    end

endmodule

// File: rtl/memsize_calc.sv
// Contiguous memory size calculator, two register stages.
// Stage 1 holds the sorted entries, stage 2 the size and its strobe.
// Assumes synchronous active-low reset; size_out only changes on a strobe.
module memsize_calc
    import memsize_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_in,
    input  logic [NCTL-1:0]         ctl_en,
    input  logic [NCTL*XCNT_W-1:0]  ctl_xchip,
    input  logic [NCTL*WORD_W-1:0]  cfg_chip0,
    input  logic [NCTL*WORD_W-1:0]  cfg_chip1,
    output logic [WORD_W-1:0]       size_out,
    output logic                    size_valid
);

    word_t [NBANK-1:0] entry;
    word_t [NBANK-1:0] sorted_d;
    word_t [NBANK-1:0] srt_q;
    logic              stg1_vld;
    word_t             total_d;

    memsize_select u_select (
        .ctl_en    (ctl_en),
        .ctl_xchip (ctl_xchip),
        .cfg_chip0 (cfg_chip0),
        .cfg_chip1 (cfg_chip1),
        .entry     (entry)
    );

    memsize_sortnet u_sort (
        .din  (entry),
        .dout (sorted_d)
    );

    // Stage 1: capture sorted entries on a request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg1_vld <= 1'b0;
            srt_q    <= '{default: ABSENT};
        end else begin
            stg1_vld <= valid_in;
            if (valid_in)
                srt_q <= sorted_d;
        end
    end

    memsize_chain u_chain (
        .sorted (srt_q),
        .total  (total_d)
    );

    // Stage 2: publish the size and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_valid <= 1'b0;
            size_out   <= '0;
        end else begin
            size_valid <= stg1_vld;
            if (stg1_vld)
                size_out <= total_d;
        end
    end

endmodule

// File: rtl/memsize_calc_chk.sv
// Property checker for memsize_calc, attached with bind.
module memsize_calc_chk
    import memsize_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              valid_in,
    input logic              stg1_vld,
    input word_t [NBANK-1:0] srt_q,
    input logic [WORD_W-1:0] size_out,
    input logic              size_valid
);

    // R1
    stage1_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> stg1_vld);

    // R1
    stage2_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stg1_vld |=> size_valid);

    // R1
    no_spurious_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stg1_vld |=> !size_valid);

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!size_valid && size_out == '0));

    // R4
    sorted_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stg1_vld |-> (srt_q[0] <= srt_q[1] && srt_q[1] <= srt_q[2] && srt_q[2] <= srt_q[3]));

    // R9
    hold_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!size_valid && $past(rst_n)) |-> $stable(size_out));

endmodule

bind memsize_calc memsize_calc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_in   (valid_in),
    .stg1_vld   (stg1_vld),
    .srt_q      (srt_q),
    .size_out   (size_out),
    .size_valid (size_valid)
);

// File: tb/memsize_calc_test.sv
`timescale 1ns/1ps
module memsize_calc_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [1:0]  ctl_en = '0;
    logic [7:0]  ctl_xchip = '0;
    logic [63:0] cfg_chip0 = '0;
    logic [63:0] cfg_chip1 = '0;
    logic [31:0] size_out;
    logic        size_valid;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    memsize_calc uut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .ctl_en(ctl_en),
        .ctl_xchip(ctl_xchip), .cfg_chip0(cfg_chip0), .cfg_chip1(cfg_chip1),
        .size_out(size_out), .size_valid(size_valid)
    );

    // Reference size from the requirements, using a plain bubble sort
    function automatic logic [31:0] ref_size(input logic [1:0] en, input logic [7:0] xc,
                                             input logic [63:0] c0, input logic [63:0] c1);
        logic [31:0] e [4];
        logic [31:0] t, st, en_a, prev_end, acc;
        e[0] = en[0] ? c0[31:0] : 32'hFFFF_FFFF;
        e[1] = (en[0] && xc[3:0] != 0) ? c1[31:0] : 32'hFFFF_FFFF;
        e[2] = en[1] ? c0[63:32] : 32'hFFFF_FFFF;
        e[3] = (en[1] && xc[7:4] != 0) ? c1[63:32] : 32'hFFFF_FFFF;
        for (int p = 0; p < 3; p++)
            for (int q = 0; q < 3 - p; q++)
                if (e[q] > e[q+1]) begin t = e[q]; e[q] = e[q+1]; e[q+1] = t; end
        if (e[0] == 32'hFFFF_FFFF) return 32'h0;
        acc = 32'h0;
        prev_end = 32'h0;
        for (int i = 0; i < 4; i++) begin
            st   = e[i] & 32'hFF00_0000;
            en_a = st | ~((e[i] & 32'h00FF_0000) << 8);
            if (i > 0 && st != prev_end + 32'h1) break;
            acc = acc + (en_a - st + 32'h1);
            prev_end = en_a;
        end
        return acc;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one request and check the strobe and the size two edges later
    task automatic run_case(input string req, input logic [1:0] en, input logic [7:0] xc,
                            input logic [63:0] c0, input logic [63:0] c1);
        logic [31:0] exp;
        exp = ref_size(en, xc, c0, c1);
        ctl_en = en; ctl_xchip = xc; cfg_chip0 = c0; cfg_chip1 = c1; valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
        check({req, " R1 early"}, {31'b0, size_valid}, 32'h0);
        @(negedge clk);
        check({req, " R1 strobe"}, {31'b0, size_valid}, 32'h1);
        check(req, size_out, exp);
        ctl_en = 2'($urandom); cfg_chip0 = {$urandom, $urandom};
        @(negedge clk);
        check("R9 strobe low", {31'b0, size_valid}, 32'h0);
        check("R9 hold", size_out, exp);
    endtask

    function automatic logic [31:0] rand_word();
        logic [7:0] base, mask;
        base = 8'(($urandom % 12) * 16);
        mask = ($urandom % 3 == 0) ? 8'hE0 : 8'hF0;
        if ($urandom % 8 == 0) mask = 8'h80;
        return {base, mask, 16'($urandom)};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 valid", {31'b0, size_valid}, 32'h0);
        check("R2 size", size_out, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: nothing present
        run_case("R7 empty", 2'b00, 8'h11, 64'h0, 64'h0);
        // R3: chip-1 ignored with zero extra-chip count
        run_case("R3 no extra", 2'b01, 8'h00, {32'h0, 32'h00F0_0000}, {32'h0, 32'h10F0_0000});
        // R3: chip-1 used with nonzero count, R6 chain of two
        run_case("R3 R6 extra", 2'b01, 8'h02, {32'h0, 32'h00F0_0000}, {32'h0, 32'h10F0_0000});
        // R4 R6: reversed order across controllers, four-bank chain
        run_case("R4 R6 four", 2'b11, 8'h11, {32'h00F0_0000, 32'h30F0_0000},
                 {32'h10F0_0000, 32'h20F0_0000});
        // R6: gap stops accumulation
        run_case("R6 gap", 2'b11, 8'h11, {32'h00F0_0000, 32'h40F0_0000},
                 {32'h10F0_0000, 32'h60F0_0000});
        // R5: low 16 bits have no effect
        run_case("R5 low bits", 2'b01, 8'h00, {32'h0, 32'h20E0_ABCD}, 64'h0);
        // R8: full space wraps to zero
        run_case("R8 wrap", 2'b01, 8'h01, {32'h0, 32'h0080_0000}, {32'h0, 32'h8080_0000});
        run_case("R8 single", 2'b10, 8'h00, {32'h0000_0000, 32'h0}, 64'h0);

        // R1: back-to-back requests give back-to-back strobes
        ctl_en = 2'b01; ctl_xchip = 8'h0; cfg_chip0 = {32'h0, 32'h00F0_0000}; valid_in = 1'b1;
        @(negedge clk);
        cfg_chip0 = {32'h0, 32'h00E0_0000};
        @(negedge clk);
        valid_in = 1'b0;
        check("R1 b2b first", size_out, 32'h1000_0000);
        check("R1 b2b strobe1", {31'b0, size_valid}, 32'h1);
        @(negedge clk);
        check("R1 b2b second", size_out, 32'h2000_0000);
        check("R1 b2b strobe2", {31'b0, size_valid}, 32'h1);
        @(negedge clk);

        // R3 R4 R5 R6: random layouts
        for (int n = 0; n < 60; n++) begin
            logic [7:0] xc;
            xc = {($urandom % 2 == 0) ? 4'h0 : 4'($urandom), ($urandom % 2 == 0) ? 4'h0 : 4'($urandom)};
            run_case("R6 random", 2'($urandom), xc, {rand_word(), rand_word()},
                     {rand_word(), rand_word()});
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule